// File: doc/BRIEF.md
# 8-bit Timer/Counter with PWM Waveform Modes

This block is a single-channel timer for a microcontroller-class subsystem. An 8-bit counter advances on a one-cycle enable pulse. The pulse comes from a free-running prescaler or from edges on an external event input. The counter follows one of four counting schemes: plain wrap-around, clear-on-match, single-slope PWM and dual-slope phase-correct PWM. A single compare value drives one waveform output. The pin action depends on both the counting scheme and a 2-bit action field.

Two sticky flags record counter overflow and compare match. Each flag has its own interrupt enable and is cleared by writing a one. The compare value is double-buffered in the PWM schemes, so that a write never cuts a pulse short. A force strobe lets software apply the configured pin action at once when the block is not in a PWM scheme.

Top module: `tmr8_pwm_timer`

## Requirements
- R1: After reset, the counter, both flags, both interrupt lines, the live compare value and the waveform output are all 0.
- R2: `clk_sel` chooses the advance pulse. Code 0 stops the counter. Codes 1 to 5 advance it once every 1, 8, 64, 256 or 1024 clocks; the prescaler is a 10-bit count that starts at zero at reset, and it fires when its low 0, 3, 6, 8 or 10 bits are all ones. Code 6 advances on a falling edge and code 7 on a rising edge of `ext_evt`, each taken from the previous clock's sample.
- R3: In mode 0 (free-running), the counter increments by one per advance pulse and wraps from 0xFF to 0x00. The overflow flag is set on the same edge at which the counter becomes 0.
- R4: In mode 2 (clear-on-match), an advance pulse while the counter equals the live compare value loads 0; otherwise the counter increments. An FF-to-00 step sets the overflow flag.
- R5: In mode 3 (fast PWM), the counter runs 0 to 0xFF and restarts. The FF-to-00 step sets the overflow flag.
- R6: In mode 1 (phase-correct PWM), the counter climbs to 0xFF, stays there for exactly one advance pulse, then falls to 0 and stays there for one pulse. The overflow flag is set on the step from 1 to 0. After reset the counter starts at 0 in the falling phase.
- R7: The compare flag is set by every advance pulse at which the counter equals the live compare value, in all modes.
- R8: In modes 0 and 2 the action applies on a compare match. Action 0 leaves the output unchanged, 1 toggles it, 2 drives it low and 3 drives it high.
- R9: In mode 3, action 2 drives the output high on the FF-to-00 step and low on any other match. Action 3 does the opposite. Actions 0 and 1 leave the output unchanged.
- R10: In mode 1, action 2 drives the output low on a match in the climbing phase and high on a match in the falling phase. Action 3 swaps these levels. Actions 0 and 1 leave the output unchanged. The pulse held at 0xFF counts as climbing, and the pulse held at 0 counts as falling.
- R11: A `force_cmp` pulse in modes 0 or 2 applies the R8 action on the next edge. It sets no flag and does not touch the counter. In modes 1 and 3 the pulse has no effect.
- R12: A compare write always loads a buffer. In modes 0 and 2 it also updates the live compare value on the next edge. In mode 3 the live value takes the buffer on the FF-to-00 step. In mode 1 the live value takes the buffer on the advance pulse at 0xFF.
- R13: A one on `ovf_clr` or `cmp_clr` clears that flag, but a setting event on the same edge wins. Each interrupt line is its flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Advance source select (R2) |
| wave_mode | input | 2 | Counting scheme: 0 free, 1 phase-correct, 2 clear-on-match, 3 fast PWM |
| out_act | input | 2 | Waveform action code |
| force_cmp | input | 1 | One-cycle force strobe |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| ext_evt | input | 1 | External event input |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear for overflow flag |
| cmp_clr | input | 1 | Write-one-to-clear for compare flag |
| count | output | 8 | Counter value |
| cmp_live | output | 8 | Compare value in use |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| ovf_irq | output | 1 | Overflow interrupt |
| cmp_irq | output | 1 | Compare interrupt |
| wave_out | output | 1 | Waveform output |

## Verification
The bound assertions check several invariants on every cycle:
- a stopped source freezes the counter;
- an overflow flag only rises with the counter at zero;
- the compare flag only rises after a match pulse;
- the phase-correct peak lasts one pulse;
- a force strobe never raises a flag;
- the live compare value stays put in fast PWM between wraps.

The exact waveform levels per action code, the prescaler phases, the buffered compare hand-over and the set-beats-clear priority need whole scenarios. The bench covers them with a cycle-exact arithmetic model, run over every mode, action code and several compare values, under pseudo-random strobes.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic [1:0] {
      WM_FREE     = 2'd0,
      WM_PHASE    = 2'd1,
      WM_CLRMATCH = 2'd2,
      WM_FAST     = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      ACT_OFF  = 2'd0,
      ACT_TOG  = 2'd1,
      ACT_LOW  = 2'd2,
      ACT_HIGH = 2'd3
   } act_e;

   // PWM schemes are exactly the odd mode codes
   function automatic logic mode_is_pwm(input wmode_e m);
      return m[0];
   endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
   parameter int PRE_W    = 10,
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] clk_sel,
   input  logic       ext_evt,
   output logic       tick
);
   localparam int NTAP = 4;
   localparam int TAP_BITS [NTAP] = '{3, 6, 8, 10};

   if (PRE_W < 10) begin : g_bad_width
      $error("tmr8_prescaler: PRE_W must cover the deepest tap");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  tap_hit;
   logic             ext_s;
   logic             ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << TAP_BITS[g]) - 64'd1);
      assign tap_hit[g] = (pre_q & MASK) == MASK;
   end

   if (EXT_SYNC) begin : g_ext_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_s <= 1'b0;
         else        ext_s <= ext_evt;
      end
   end else begin : g_ext_direct
      assign ext_s = ext_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= 1'b0;
      else        ext_q <= ext_s;
   end

   always_comb begin
      unique case (clk_sel)
         3'd0:    tick = 1'b0;
         3'd1:    tick = 1'b1;
         3'd2:    tick = tap_hit[0];
         3'd3:    tick = tap_hit[1];
         3'd4:    tick = tap_hit[2];
         3'd5:    tick = tap_hit[3];
         3'd6:    tick = ~ext_s & ext_q;
         default: tick = ext_s & ~ext_q;
      endcase
   end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  wmode_e           mode,
   input  logic [CNT_W-1:0] cmp_live,
   output logic [CNT_W-1:0] count,
   output logic             down,
   output logic             ovf_ev,
   output logic             match_ev,
   output logic             wrap_ev,
   output logic             load_ev
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             down_q, down_d;
   logic             at_max, at_zero, hit;

   assign at_max  = cnt_q == MAXV;
   assign at_zero = cnt_q == '0;
   assign hit     = cnt_q == cmp_live;

   always_comb begin
      cnt_d  = cnt_q;
      down_d = 1'b1;
      unique case (mode)
         WM_FREE, WM_FAST: if (tick) cnt_d = cnt_q + 1'b1;
         WM_CLRMATCH:      if (tick) cnt_d = hit ? '0 : cnt_q + 1'b1;
         WM_PHASE: begin
            down_d = down_q;
            if (tick) begin
               if (down_q) begin
                  if (at_zero) begin
                     cnt_d  = ONE;
                     down_d = 1'b0;
                  end else begin
                     cnt_d = cnt_q - 1'b1;
                  end
               end else begin
                  if (at_max) begin
                     cnt_d  = MAXV - 1'b1;
                     down_d = 1'b1;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         down_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
      end
   end

   assign ovf_ev   = tick & ((mode == WM_PHASE) ? (down_q & (cnt_q == ONE)) : at_max);
   assign match_ev = tick & hit;
   assign wrap_ev  = tick & at_max;
   assign load_ev  = tick & at_max &
                     ((mode == WM_FAST) | ((mode == WM_PHASE) & ~down_q));
   assign count    = cnt_q;
   assign down     = down_q;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
   import tmr8_pkg::*;
#(
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  wmode_e mode,
   input  act_e   act,
   input  logic   force_cmp,
   input  logic   match_ev,
   input  logic   wrap_ev,
   input  logic   down,
   output logic   wave
);
   logic wave_q, wave_d;
   logic inv;

   assign inv = act[0];

   always_comb begin
      wave_d = wave_q;
      if (!mode_is_pwm(mode)) begin
         if (match_ev | force_cmp) begin
            unique case (act)
               ACT_TOG:  wave_d = ~wave_q;
               ACT_LOW:  wave_d = 1'b0;
               ACT_HIGH: wave_d = 1'b1;
               default:  wave_d = wave_q;
            endcase
         end
      end else if (act[1]) begin
         if (mode == WM_FAST) begin
            if (wrap_ev)       wave_d = ~inv;
            else if (match_ev) wave_d = inv;
         end else if (match_ev) begin
            wave_d = inv ^ down;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave_q <= IDLE_LVL;
      else        wave_q <= wave_d;
   end

   assign wave = wave_q;

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
   parameter int NFLAG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_ev,
   input  logic [NFLAG-1:0] clr,
   input  logic [NFLAG-1:0] ie,
   output logic [NFLAG-1:0] flag,
   output logic [NFLAG-1:0] irq
);
   if (NFLAG < 1) begin : g_bad_count
      $error("tmr8_flags: NFLAG must be at least one");
   end

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_q <= 1'b0;
         else if (set_ev[f]) flag_q <= 1'b1;
         else if (clr[f])    flag_q <= 1'b0;
      end
      assign flag[f] = flag_q;
      assign irq[f]  = flag_q & ie[f];
   end

endmodule

// File: rtl/tmr8_pwm_timer.sv
module tmr8_pwm_timer
   import tmr8_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PRE_W    = 10,
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   input  logic [1:0]       wave_mode,
   input  logic [1:0]       out_act,
   input  logic             force_cmp,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             ext_evt,
   input  logic             ovf_ie,
   input  logic             cmp_ie,
   input  logic             ovf_clr,
   input  logic             cmp_clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cmp_live,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             ovf_irq,
   output logic             cmp_irq,
   output logic             wave_out
);
   localparam int NFLAG = 2;
   localparam int F_OVF = 0;
   localparam int F_CMP = 1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr8_pwm_timer: CNT_W must be at least 2");
   end

   wmode_e mode;
   act_e   act;
   assign mode = wmode_e'(wave_mode);
   assign act  = act_e'(out_act);

   logic             adv_tick;
   logic             cnt_down;
   logic             ovf_ev, match_ev, wrap_ev, load_ev;
   logic [CNT_W-1:0] buf_q, live_q;
   logic [NFLAG-1:0] fl_set, fl_clr, fl_ie, fl_q, fl_irq;

   tmr8_prescaler #(.PRE_W(PRE_W), .EXT_SYNC(EXT_SYNC)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .ext_evt (ext_evt),
      .tick    (adv_tick)
   );

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (adv_tick),
      .mode     (mode),
      .cmp_live (live_q),
      .count    (count),
      .down     (cnt_down),
      .ovf_ev   (ovf_ev),
      .match_ev (match_ev),
      .wrap_ev  (wrap_ev),
      .load_ev  (load_ev)
   );

   // compare buffer and live value; PWM schemes hand over only at update points
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         live_q <= '0;
      end else begin
         if (cmp_wr) buf_q <= cmp_wdata;
         if (!mode_is_pwm(mode)) begin
            if (cmp_wr) live_q <= cmp_wdata;
         end else if (load_ev) begin
            live_q <= buf_q;
         end
      end
   end

   tmr8_wave #(.IDLE_LVL(1'b0)) u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .act       (act),
      .force_cmp (force_cmp),
      .match_ev  (match_ev),
      .wrap_ev   (wrap_ev),
      .down      (cnt_down),
      .wave      (wave_out)
   );

   assign fl_set[F_OVF] = ovf_ev;
   assign fl_set[F_CMP] = match_ev;
   assign fl_clr[F_OVF] = ovf_clr;
   assign fl_clr[F_CMP] = cmp_clr;
   assign fl_ie[F_OVF]  = ovf_ie;
   assign fl_ie[F_CMP]  = cmp_ie;

   tmr8_flags #(.NFLAG(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (fl_set),
      .clr    (fl_clr),
      .ie     (fl_ie),
      .flag   (fl_q),
      .irq    (fl_irq)
   );

   assign cmp_live = live_q;
   assign ovf_flag = fl_q[F_OVF];
   assign cmp_flag = fl_q[F_CMP];
   assign ovf_irq  = fl_irq[F_OVF];
   assign cmp_irq  = fl_irq[F_CMP];

endmodule

// File: rtl/tmr8_pwm_timer_chk.sv
module tmr8_pwm_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       clk_sel,
   input logic [1:0]       wave_mode,
   input logic             force_cmp,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_live,
   input logic             ovf_flag,
   input logic             cmp_flag,
   input logic             tick,
   input logic             down
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   // R2: stopped source freezes the counter
   a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |=> $stable(count));

   // R3 / R6: overflow flag only rises with the counter at zero
   a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (count == '0));

   // R6: phase-correct peak lasts one advance pulse
   a_r6_peak_single: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode == 2'd1 && tick && !down && count == MAXV) |=> (count == MAXV - 1'b1));

   // R7: compare flag only rises after a match pulse
   a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag) |-> $past(tick && count == cmp_live));

   // R11: force strobe without an advance pulse raises no flag
   a_r11_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (force_cmp && !tick) |=> !$rose(cmp_flag));

   // R12: fast PWM keeps the live compare value between wraps
   a_r12_fast_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode == 2'd3 && !(tick && count == MAXV)) |=> $stable(cmp_live));

endmodule

bind tmr8_pwm_timer tmr8_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_sel   (clk_sel),
   .wave_mode (wave_mode),
   .force_cmp (force_cmp),
   .count     (count),
   .cmp_live  (cmp_live),
   .ovf_flag  (ovf_flag),
   .cmp_flag  (cmp_flag),
   .tick      (adv_tick),
   .down      (cnt_down)
);

// File: tb/tmr8_pwm_timer_bench.sv
`timescale 1ns/100ps
module tmr8_pwm_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] clk_sel = 3'd0;
   logic [1:0] wave_mode = 2'd0;
   logic [1:0] out_act = 2'd0;
   logic       force_cmp = 1'b0;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_wdata = 8'd0;
   logic       ext_evt = 1'b0;
   logic       ovf_ie = 1'b0;
   logic       cmp_ie = 1'b0;
   logic       ovf_clr = 1'b0;
   logic       cmp_clr = 1'b0;
   logic [7:0] count, cmp_live;
   logic       ovf_flag, cmp_flag, ovf_irq, cmp_irq, wave_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   tmr8_pwm_timer u_tmr8_pwm_timer (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
      .out_act(out_act), .force_cmp(force_cmp), .cmp_wr(cmp_wr),
      .cmp_wdata(cmp_wdata), .ext_evt(ext_evt), .ovf_ie(ovf_ie),
      .cmp_ie(cmp_ie), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .count(count),
      .cmp_live(cmp_live), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
      .ovf_irq(ovf_irq), .cmp_irq(cmp_irq), .wave_out(wave_out)
   );

   // ---------------- arithmetic reference model ----------------
   int m_pre, m_cnt, m_down, m_live, m_buf, m_ovf, m_cf, m_wave, m_extq;

   always @(posedge clk or negedge rst_n) begin : ref_model
      int t, hit, nc, nd, ovfe, mate, ld, w, inv;
      if (!rst_n) begin
         m_pre <= 0; m_extq <= 0; m_cnt <= 0; m_down <= 1; m_live <= 0;
         m_buf <= 0; m_ovf <= 0; m_cf <= 0; m_wave <= 0;
      end else begin
         case (clk_sel)
            3'd0: t = 0;
            3'd1: t = 1;
            3'd2: t = int'(m_pre % 8 == 7);
            3'd3: t = int'(m_pre % 64 == 63);
            3'd4: t = int'(m_pre % 256 == 255);
            3'd5: t = int'(m_pre % 1024 == 1023);
            3'd6: t = int'(ext_evt == 1'b0 && m_extq == 1);
            default: t = int'(ext_evt == 1'b1 && m_extq == 0);
         endcase
         m_pre  <= (m_pre + 1) % 1024;
         m_extq <= int'(ext_evt);
         hit = int'(m_cnt == m_live);
         nc = m_cnt; nd = m_down; ovfe = 0; ld = 0; w = m_wave;
         if (t != 0) begin
            case (wave_mode)
               2'd0: begin nc = (m_cnt + 1) % 256; ovfe = int'(m_cnt == 255); end
               2'd2: begin nc = (hit != 0) ? 0 : (m_cnt + 1) % 256; ovfe = int'(m_cnt == 255); end
               2'd3: begin nc = (m_cnt + 1) % 256; ovfe = int'(m_cnt == 255); ld = ovfe; end
               default: begin
                  if (m_down != 0) begin
                     if (m_cnt == 0) begin nd = 0; nc = 1; end
                     else begin nc = m_cnt - 1; ovfe = int'(m_cnt == 1); end
                  end else begin
                     if (m_cnt == 255) begin nd = 1; nc = 254; ld = 1; end
                     else nc = m_cnt + 1;
                  end
               end
            endcase
         end
         if (wave_mode != 2'd1) nd = 1;
         mate = int'(t != 0 && hit != 0);
         inv = int'(out_act == 2'd3);
         if (wave_mode == 2'd0 || wave_mode == 2'd2) begin
            if (mate != 0 || force_cmp) begin
               if (out_act == 2'd1) w = 1 - m_wave;
               else if (out_act == 2'd2) w = 0;
               else if (out_act == 2'd3) w = 1;
            end
         end else if (out_act >= 2'd2) begin
            if (wave_mode == 2'd3) begin
               if (t != 0 && m_cnt == 255) w = 1 - inv;
               else if (mate != 0) w = inv;
            end else if (mate != 0) begin
               w = (m_down != 0) ? 1 - inv : inv;
            end
         end
         if (cmp_wr) m_buf <= int'(cmp_wdata);
         if (wave_mode == 2'd0 || wave_mode == 2'd2) begin
            if (cmp_wr) m_live <= int'(cmp_wdata);
         end else if (ld != 0) begin
            m_live <= m_buf;
         end
         m_ovf  <= (ovfe != 0) ? 1 : (ovf_clr ? 0 : m_ovf);
         m_cf   <= (mate != 0) ? 1 : (cmp_clr ? 0 : m_cf);
         m_cnt  <= nc;
         m_down <= nd;
         m_wave <= w;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string ctag, input string wtag);
      chk(ctag,  "count",    int'(count),    m_cnt);
      chk(ctag,  "ovf_flag", int'(ovf_flag), m_ovf);
      chk("R7",  "cmp_flag", int'(cmp_flag), m_cf);
      chk(wtag,  "wave_out", int'(wave_out), m_wave);
      chk("R12", "cmp_live", int'(cmp_live), m_live);
      chk("R13", "ovf_irq",  int'(ovf_irq),  int'(ovf_flag & ovf_ie));
      chk("R13", "cmp_irq",  int'(cmp_irq),  int'(cmp_flag & cmp_ie));
   endtask

   task automatic quiet();
      force_cmp = 1'b0; cmp_wr = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
      ext_evt = 1'b0; ovf_ie = 1'b0; cmp_ie = 1'b0;
   endtask

   task automatic drive_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      force_cmp = (lfsr[3:0] == 4'd0);
      cmp_wr    = (lfsr[11:4] == 8'd0);
      cmp_wdata = lfsr[15:8];
      ovf_clr   = (lfsr[6:4] == 3'd0);
      cmp_clr   = (lfsr[9:7] == 3'd0);
      ovf_ie    = lfsr[10];
      cmp_ie    = lfsr[12];
      ext_evt   = lfsr[13];
   endtask

   task automatic scn(input int md, input int act, input int sel, input int cv,
                      input int n, input string ctag, input string wtag);
      @(negedge clk);
      rst_n = 1'b0;
      quiet();
      wave_mode = 2'(md); out_act = 2'(act); clk_sel = 3'(sel);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_wr = 1'b1; cmp_wdata = 8'(cv);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all(ctag, wtag);
         drive_rand();
      end
   endtask

   function automatic string cnt_tag(input int md);
      case (md)
         0: return "R3";
         1: return "R6";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   function automatic string wave_tag(input int md);
      case (md)
         1: return "R10";
         3: return "R9";
         default: return "R8";
      endcase
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (180000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int cvals [4];
      cvals = '{0, 1, 127, 255};

      // R1: reset state, counter stopped
      quiet();
      ovf_ie = 1'b1; cmp_ie = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "count",    int'(count),    0);
      chk("R1", "ovf_flag", int'(ovf_flag), 0);
      chk("R1", "cmp_flag", int'(cmp_flag), 0);
      chk("R1", "irqs",     int'(ovf_irq | cmp_irq), 0);
      chk("R1", "wave_out", int'(wave_out), 0);
      chk("R1", "cmp_live", int'(cmp_live), 0);

      // R11: force ignored in fast PWM, applied without side effects in mode 0
      wave_mode = 2'd3; out_act = 2'd2; force_cmp = 1'b1;
      @(negedge clk);
      force_cmp = 1'b0;
      @(negedge clk);
      chk("R11", "pwm force wave", int'(wave_out), 0);
      chk("R11", "pwm force flag", int'(cmp_flag), 0);
      wave_mode = 2'd0; out_act = 2'd1; force_cmp = 1'b1;
      @(negedge clk);
      force_cmp = 1'b0;
      chk("R11", "force toggles wave", int'(wave_out), 1);
      chk("R11", "force no flag",      int'(cmp_flag), 0);
      chk("R11", "force keeps count",  int'(count),    0);
      wave_mode = 2'd1; force_cmp = 1'b1;
      @(negedge clk);
      force_cmp = 1'b0;
      @(negedge clk);
      chk("R11", "phase force wave", int'(wave_out), 1);

      // R13: set beats clear, irq gating
      @(negedge clk);
      rst_n = 1'b0; quiet(); wave_mode = 2'd0; out_act = 2'd0; clk_sel = 3'd1;
      @(negedge clk);
      rst_n = 1'b1; cmp_wr = 1'b1; cmp_wdata = 8'd5;
      @(negedge clk);
      cmp_wr = 1'b0;
      for (int i = 0; i < 300 && count != 8'd5; i++) @(negedge clk);
      cmp_clr = 1'b1;
      @(negedge clk);
      chk("R13", "set beats clear", int'(cmp_flag), 1);
      chk("R13", "irq masked",      int'(cmp_irq),  0);
      cmp_ie = 1'b1;
      @(negedge clk);
      cmp_clr = 1'b0;
      chk("R13", "flag cleared", int'(cmp_flag), 0);
      for (int i = 0; i < 300 && !cmp_flag; i++) @(negedge clk);
      chk("R13", "irq enabled", int'(cmp_irq), 1);
      chk("R3",  "overflow seen", int'(ovf_flag), 1);

      // sweep: every mode, every action, several compare values, divide by 1
      for (int md = 0; md < 4; md++)
         for (int act = 0; act < 4; act++)
            for (int k = 0; k < 4; k++)
               scn(md, act, 1, cvals[k], 1100, cnt_tag(md), wave_tag(md));

      // R2: prescaler taps and external edges
      scn(0, 1, 2, 3, 2500, "R2", "R8");
      scn(0, 1, 3, 3, 2500, "R2", "R8");
      scn(2, 1, 4, 2, 3000, "R2", "R8");
      scn(0, 1, 5, 1, 6000, "R2", "R8");
      scn(0, 1, 0, 0, 500,  "R2", "R8");
      scn(0, 1, 6, 9, 1500, "R2", "R8");
      scn(3, 2, 7, 9, 1500, "R2", "R9");

      summary();
      $finish;
   end

endmodule